// File: doc/BRIEF.md
# Multi-mode asynchronous serial port

This block is a full-duplex asynchronous serial port for a microcontroller-style peripheral bus. A two-bit mode field in its control register picks one of three frame formats. The first is a 10-bit frame: a start bit, eight data bits and a stop bit. The other two are 11-bit frames that add a ninth data bit before the stop bit. Software can use that ninth bit as a command/data marker. Data bits always travel least-significant bit first. An external baud tick paces both directions, and one bit period lasts a fixed number of ticks.

Software starts a transmission by writing a byte to the data address. The mode and the outgoing ninth bit must already be set in the control register. Reception is armed with an enable bit and begins on a falling edge of the serial input. Each bit is decided by a majority of three samples near the middle of the bit period. A completed frame lands in the receive buffer together with its ninth bit, which is the stop bit in the 10-bit mode. This only happens if the receive-complete flag is clear. Both completion flags stay set until software clears them through the control register.

Top module: `mmsp_port`

## Requirements
- R1: After reset the serial output is high and both flags are 0. A read of the control address (bus_addr=0) and of the data address (bus_addr=1) each returns 0x00, one cycle after bus_addr is presented.
- R2: Control byte layout: bits 7:6 are the mode, bit 5 is receive enable, bit 4 is the transmit ninth bit, bit 3 is the receive ninth bit, bit 1 is the transmit flag and bit 0 is the receive flag. In mode 01, a write to the data address sends a 10-bit frame on ser_out: 0, the eight data bits LSB first, then 1. Each bit lasts 16 baud ticks.
- R3: In modes 10 and 11, a data write sends an 11-bit frame: 0, the eight data bits LSB first, the transmit ninth bit, then 1.
- R4: The transmit flag is 0 during the last bit before the stop bit. It becomes 1 one clock after the stop bit begins on ser_out.
- R5: A data write made while a frame is still being sent is ignored, and the frame in progress goes out unchanged.
- R6: In mode 01 with receive enable set, a frame on ser_in places its byte in the receive buffer and its stop bit in control bit 3, and sets the receive flag.
- R7: In modes 10 and 11 with receive enable set, the receive buffer takes the eight data bits and control bit 3 takes the received ninth bit.
- R8: With receive enable clear, a frame on ser_in leaves the receive flag and the receive buffer unchanged.
- R9: A low pulse on ser_in that is shorter than half a bit period is treated as a false start and receives nothing. A real frame that follows it is received correctly.
- R10: Each received bit takes the majority of three samples around the middle of its period, so a one-clock glitch at the middle does not change the received value.
- R11: While the receive flag is set, a completed frame is discarded: the buffer, control bit 3 and the flag all keep their values.
- R12: In mode 00 a data write produces no frame (ser_out stays high, the transmit flag stays 0), and no frame is received.
- R13: Both flags stay set until a control write stores 0 into them. The mode and ninth-bit fields read back as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit period |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = data (write: transmit, read: receive buffer) |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line, high when idle |
| tx_flag | output | 1 | Transmit flag (control bit 1) |
| rx_flag | output | 1 | Receive flag (control bit 0) |

## Verification
The bench builds the port with an 8-bit data path, 16 ticks per bit and a two-stage input synchronizer, and it holds baud_tick high. One bit is therefore exactly 16 clocks, and a whole frame costs under 200 cycles. That makes it affordable to send and receive all 256 byte values in the 10-bit mode, and to sweep 32 values for each combination of 9-bit mode and ninth-bit value. Because bit boundaries are known to the cycle, the bench can place a glitch exactly on the middle sample, shape a sub-half-bit false start, and catch the transmit flag in the bits on either side of the stop bit.

// File: rtl/mmsp_pkg.sv
package mmsp_pkg;

  // control byte field positions
  localparam int B_RXF = 0;
  localparam int B_TXF = 1;
  localparam int B_RB9 = 3;
  localparam int B_TB9 = 4;
  localparam int B_REN = 5;
  localparam int B_MLO = 6;
  localparam int B_MHI = 7;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_NINTH,
    RS_STOP
  } rx_state_e;

  // mode 00 leaves the port inert; 01 is the 8-bit frame; 1x the 9-bit frames
  function automatic logic mode_on(input logic [1:0] m);
    return |m;
  endfunction

  function automatic logic mode_nine(input logic [1:0] m);
    return m[1];
  endfunction

endpackage

// File: rtl/mmsp_sync.sv
module mmsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign fall  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/mmsp_tx.sv
module mmsp_tx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic          nine,
  input  logic          bit9,
  input  logic [DW-1:0] data,
  output logic          ser_out,
  output logic          busy,
  output logic          stop_pulse
);

  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FW);
  localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);

  logic [FW-1:0] frame_q;
  logic [IW-1:0] idx_q, last_q;
  logic [CW-1:0] tcnt_q;
  logic          accept;
  logic [IW-1:0] idx_nx;

  assign accept = start && !busy;
  assign idx_nx = IW'(idx_q + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q    <= '1;
      idx_q      <= '0;
      last_q     <= '0;
      tcnt_q     <= '0;
      busy       <= 1'b0;
      ser_out    <= 1'b1;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (accept) begin
        // frame held LSB first: start bit at index 0
        frame_q <= nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
        last_q  <= nine ? IW'(FW - 1) : IW'(FW - 2);
        idx_q   <= '0;
        tcnt_q  <= '0;
        busy    <= 1'b1;
        ser_out <= 1'b0;
      end else if (busy && tick) begin
        if (tcnt_q == T_LAST) begin
          tcnt_q <= '0;
          if (idx_q == last_q) begin
            busy    <= 1'b0;
            ser_out <= 1'b1;
          end else begin
            idx_q      <= idx_nx;
            ser_out    <= frame_q[idx_nx];
            stop_pulse <= (idx_nx == last_q);
          end
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);                                   // R1
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !ser_out));             // R2
  AST_TX_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> busy);                            // R5
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> (ser_out && busy));                    // R4

endmodule

// File: rtl/mmsp_rx.sv
module mmsp_rx
  import mmsp_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          enable,
  input  logic          nine,
  input  logic          line,
  input  logic          fall,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9
);

  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(DW);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] T_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] T_S0   = CW'(MID - 1);
  localparam logic [CW-1:0] T_S1   = CW'(MID);
  localparam logic [CW-1:0] T_S2   = CW'(MID + 1);
  localparam logic [CW-1:0] T_STOP = CW'(MID + 2);

  rx_state_e     st_q;
  logic [CW-1:0] tcnt_q;
  logic [IW-1:0] idx_q;
  logic [2:0]    vote_q;
  logic [DW-1:0] sh_q;
  logic          nine_q, ninth_q;
  logic          maj, bit_end;

  assign maj = (vote_q[0] & vote_q[1]) | (vote_q[0] & vote_q[2]) | (vote_q[1] & vote_q[2]);
  // the stop bit is closed just after its votes so the next start edge is not missed
  assign bit_end = (st_q == RS_STOP) ? (tcnt_q == T_STOP) : (tcnt_q == T_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RS_IDLE;
      tcnt_q  <= '0;
      idx_q   <= '0;
      vote_q  <= '0;
      sh_q    <= '0;
      nine_q  <= 1'b0;
      ninth_q <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      bit9    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st_q == RS_IDLE) begin
        if (enable && fall) begin
          st_q   <= RS_START;
          tcnt_q <= '0;
          vote_q <= '0;
          nine_q <= nine;
        end
      end else if (tick) begin
        if (tcnt_q == T_S0) vote_q[0] <= line;
        if (tcnt_q == T_S1) vote_q[1] <= line;
        if (tcnt_q == T_S2) vote_q[2] <= line;
        if (bit_end) begin
          tcnt_q <= '0;
          case (st_q)
            RS_START: begin
              if (maj) begin
                st_q <= RS_IDLE;
              end else begin
                st_q  <= RS_DATA;
                idx_q <= '0;
              end
            end
            RS_DATA: begin
              sh_q <= {maj, sh_q[DW-1:1]};
              if (idx_q == IW'(DW - 1)) st_q <= nine_q ? RS_NINTH : RS_STOP;
              else                      idx_q <= idx_q + 1'b1;
            end
            RS_NINTH: begin
              ninth_q <= maj;
              st_q    <= RS_STOP;
            end
            RS_STOP: begin
              done <= 1'b1;
              data <= sh_q;
              bit9 <= nine_q ? ninth_q : maj;
              st_q <= RS_IDLE;
            end
            default: st_q <= RS_IDLE;
          endcase
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  AST_RX_STAY_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == RS_IDLE && !enable) |=> (st_q == RS_IDLE));          // R8
  AST_RX_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    done |-> (st_q == RS_IDLE));                                   // R6
  AST_RX_FALSE_START: assert property (@(posedge clk) disable iff (rst)
    (st_q == RS_START && tick && bit_end && maj) |=> (st_q == RS_IDLE && !done)); // R9

endmodule

// File: rtl/mmsp_port.sv
module mmsp_port
  import mmsp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ser_in,
  output logic          ser_out,
  output logic          tx_flag,
  output logic          rx_flag
);

  logic [1:0]    mode_q;
  logic          ren_q, tb9_q, rb9_q, txf_q, rxf_q;
  logic [DW-1:0] rbuf_q;

  logic          ctl_wr, dat_wr, cap;
  logic          tx_busy, tx_stop;
  logic          rx_level, rx_fall, rx_done, rx_b9;
  logic [DW-1:0] rx_data;
  logic [7:0]    ctl_byte;

  assign ctl_wr = bus_we && !bus_addr;
  assign dat_wr = bus_we &&  bus_addr;
  assign cap    = rx_done && !rxf_q;

  assign ctl_byte = {mode_q, ren_q, tb9_q, rb9_q, 1'b0, txf_q, rxf_q};

  mmsp_sync #(.STAGES(SYNC)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (ser_in),
    .level (rx_level),
    .fall  (rx_fall)
  );

  mmsp_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick       (baud_tick),
    .start      (dat_wr && mode_on(mode_q)),
    .nine       (mode_nine(mode_q)),
    .bit9       (tb9_q),
    .data       (bus_wdata),
    .ser_out    (ser_out),
    .busy       (tx_busy),
    .stop_pulse (tx_stop)
  );

  mmsp_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .tick   (baud_tick),
    .enable (ren_q && mode_on(mode_q)),
    .nine   (mode_nine(mode_q)),
    .line   (rx_level),
    .fall   (rx_fall),
    .done   (rx_done),
    .data   (rx_data),
    .bit9   (rx_b9)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= 2'b00;
      ren_q     <= 1'b0;
      tb9_q     <= 1'b0;
      rb9_q     <= 1'b0;
      txf_q     <= 1'b0;
      rxf_q     <= 1'b0;
      rbuf_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (ctl_wr) begin
        mode_q <= bus_wdata[B_MHI:B_MLO];
        ren_q  <= bus_wdata[B_REN];
        tb9_q  <= bus_wdata[B_TB9];
        rb9_q  <= bus_wdata[B_RB9];
        txf_q  <= bus_wdata[B_TXF];
        rxf_q  <= bus_wdata[B_RXF];
      end
      // hardware events win over a same-cycle software write
      if (tx_stop) txf_q <= 1'b1;
      if (cap) begin
        rxf_q  <= 1'b1;
        rb9_q  <= rx_b9;
        rbuf_q <= rx_data;
      end
      bus_rdata <= bus_addr ? rbuf_q : DW'(ctl_byte);
    end
  end

  assign tx_flag = txf_q;
  assign rx_flag = rxf_q;

  AST_RX_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    rxf_q |=> $stable(rbuf_q));                            // R11
  AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rxf_q && !ctl_wr) |=> rxf_q);                         // R13
  AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    tx_stop |=> txf_q);                                    // R4
  AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!mode_on(mode_q) && !tx_busy) |=> ser_out);           // R12

endmodule

// File: tb/test_mmsp_port.sv
`timescale 1ns/1ps
module test_mmsp_port;

  localparam int DW  = 8;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sin = 1'b1;
  logic       sout, txf, rxf;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mmsp_port #(.DW(DW), .OVS(OVS), .SYNC(2)) i_mmsp_port (
    .clk       (clk),
    .rst       (rst),
    .baud_tick (tick),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .ser_in    (sin),
    .ser_out   (sout),
    .tx_flag   (txf),
    .rx_flag   (rxf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  // samples the middle of each bit of a frame whose start edge lies lead+0.5 clocks back
  task automatic cap_tx(input int nb, input int lead, output logic [10:0] bits,
                        output logic f_pre, output logic f_stop);
    bits = '1; f_pre = 1'b0; f_stop = 1'b0;
    repeat (8 - lead) @(negedge clk);
    bits[0] = sout;
    for (int i = 1; i < nb; i++) begin
      repeat (OVS) @(negedge clk);
      bits[i] = sout;
      if (i == nb - 2) f_pre  = txf;
      if (i == nb - 1) f_stop = txf;
    end
    repeat (9) @(negedge clk);
  endtask

  task automatic send_rx(input logic [10:0] bits, input int nb, input int gl);
    for (int i = 0; i < nb; i++) begin
      for (int j = 0; j < OVS; j++) begin
        sin = (i == gl && j == 9) ? ~bits[i] : bits[i];
        @(negedge clk);
      end
    end
    sin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic tx_one(input logic [1:0] m, input logic b9, input logic [7:0] d, input string req);
    logic [10:0] bits, exp;
    logic        fp, fs;
    int          nb;
    nb  = m[1] ? 11 : 10;
    exp = m[1] ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    wr(1'b0, {m, 1'b0, b9, 4'b0000});
    wr(1'b1, d);
    cap_tx(nb, 0, bits, fp, fs);
    chk(req, int'(bits), int'(exp));
    chk("R4 flag before stop", int'(fp), 0);
    chk("R4 flag in stop", int'(fs), 1);
  endtask

  task automatic rx_one(input logic [1:0] m, input logic b9, input logic [7:0] d,
                        input int gl, input string req);
    logic [7:0] v;
    wr(1'b0, {m, 6'b100000});
    send_rx({1'b1, b9, d, 1'b0}, m[1] ? 11 : 10, gl);
    chk({req, " flag"}, int'(rxf), 1);
    rd(1'b1, v);
    chk({req, " data"}, int'(v), int'(d));
    rd(1'b0, v);
    chk({req, " ninth"}, int'(v[3]), int'(b9));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [10:0] bits;
    logic        fp, fs;
    int          lows;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 ser_out", int'(sout), 1);
    chk("R1 tx_flag", int'(txf), 0);
    chk("R1 rx_flag", int'(rxf), 0);
    rd(1'b0, v); chk("R1 control", int'(v), 0);
    rd(1'b1, v); chk("R1 buffer", int'(v), 0);

    // R2: every byte in the 10-bit frame
    for (int d = 0; d < 256; d++) tx_one(2'b01, 1'b0, 8'(d), "R2 frame");

    // R3: 9-bit frames, both modes, both ninth-bit values
    for (int m = 2; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < 32; k++)
          tx_one(2'(m), 1'(b), 8'(k * 37 + b * 11 + m), "R3 frame");

    // R5: second write during a frame is ignored
    wr(1'b0, 8'h40);
    wr(1'b1, 8'hA5);
    wr(1'b1, 8'h5A);
    cap_tx(10, 2, bits, fp, fs);
    chk("R5 frame kept", int'(bits), int'({2'b11, 8'hA5, 1'b0}));

    // R6: 10-bit receive, all bytes, stop bit in bit 3
    for (int d = 0; d < 256; d++) rx_one(2'b01, 1'b1, 8'(d), -1, "R6");
    rx_one(2'b01, 1'b0, 8'h3C, -1, "R6 low stop");

    // R7: 9-bit receive
    for (int m = 2; m < 4; m++)
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < 32; k++)
          rx_one(2'(m), 1'(b), 8'(k * 53 + b * 7 + m), -1, "R7");

    // R10: single-clock glitch on the middle sample
    rx_one(2'b01, 1'b1, 8'h96, 3, "R10 data bit");
    rx_one(2'b10, 1'b1, 8'h0F, 9, "R10 ninth bit");
    rx_one(2'b01, 1'b1, 8'h6B, 0, "R10 start bit");

    // R9: short low pulse is a false start
    wr(1'b0, 8'h60);
    sin = 1'b0;
    repeat (4) @(negedge clk);
    sin = 1'b1;
    repeat (40) @(negedge clk);
    chk("R9 no frame", int'(rxf), 0);
    rx_one(2'b01, 1'b1, 8'hC3, -1, "R9 after false start");

    // R8: receiver disabled
    wr(1'b0, 8'h40);
    send_rx({2'b11, 8'h11, 1'b0}, 10, -1);
    chk("R8 flag", int'(rxf), 0);
    rd(1'b1, v); chk("R8 buffer", int'(v), 8'hC3);

    // R11: frame arriving while the flag is set is dropped
    rx_one(2'b01, 1'b1, 8'h21, -1, "R11 first");
    send_rx({2'b10, 8'hDE, 1'b0}, 10, -1);
    chk("R11 flag", int'(rxf), 1);
    rd(1'b1, v); chk("R11 buffer", int'(v), 8'h21);
    rd(1'b0, v); chk("R11 ninth", int'(v[3]), 1);

    // R13: flags sticky until written 0; fields read back
    repeat (50) @(negedge clk);
    chk("R13 rx sticky", int'(rxf), 1);
    wr(1'b0, 8'h60);
    chk("R13 rx cleared", int'(rxf), 0);
    wr(1'b0, 8'h40);
    wr(1'b1, 8'h77);
    repeat (200) @(negedge clk);
    chk("R13 tx sticky", int'(txf), 1);
    wr(1'b0, 8'h40);
    chk("R13 tx cleared", int'(txf), 0);
    wr(1'b0, 8'hD8);
    rd(1'b0, v); chk("R13 readback", int'(v), 8'hD8);

    // R12: mode 00 is inert
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h00);
    lows = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (!sout) lows++;
    end
    chk("R12 no tx", lows, 0);
    chk("R12 tx flag", int'(txf), 0);
    send_rx({2'b11, 8'h55, 1'b0}, 10, -1);
    chk("R12 rx flag", int'(rxf), 0);
    rd(1'b1, v); chk("R12 buffer", int'(v), 8'h21);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule